// File: doc/BRIEF.md
# Processor Event Priority Arbiter

This block sits between the sources of processor events and the logic that dispatches a handler for them. Each cycle it looks at every pending request: machine checks, a trap raised on a task switch, external interventions, breakpoint traps left by the previous instruction, non-maskable and maskable external interrupts, and faults from fetching, decoding or executing an instruction. It picks the single most urgent one and reports its class number and an 8-bit vector.

The result sits in a holding register. Once loaded it stays unchanged until the consumer takes it with a one-cycle accept pulse. A request that loses keeps waiting for as long as its source holds it. The interrupt-enable flag gates the maskable interrupt and nothing else. A maskable interrupt whose vector falls in the range kept for exceptions (below 32) is never granted. It raises a protocol-error output instead.

Top module: `evt_arbiter`

## Requirements
- R1: When several requests are pending, the winner follows this fixed order, reported on `gnt_class` as 0 to 7: machine check (0), task-switch trap (1), external intervention (2), breakpoint trap (3), external interrupt (4), fetch fault (5), decode fault (6), execute fault (7).
- R2: Machine check reports vector 18, task-switch trap reports vector 1, and breakpoint reports vector 3. Intervention, fetch-fault and execute-fault grants report the vector supplied on their own vector input.
- R3: Within class 4, the non-maskable interrupt wins over the maskable one and always reports vector 2, whatever the state of `int_en`.
- R4: A maskable interrupt is granted only while `int_en` is 1, and then with its own vector. While `int_en` is 0 it produces no grant and no error.
- R5: A maskable interrupt with `int_en` at 1 and a vector below 32 is not granted. `intr_err` is 1 in the cycle after such a request is sampled and 0 otherwise. A vector of exactly 32 is legal.
- R6: A request sampled at a clock edge while the holding register is free (`gnt_valid` is 0 or `gnt_take` is 1) appears on the grant outputs right after that edge. While `gnt_valid` is 1 and `gnt_take` is 0, the class and vector stay unchanged, even if a more urgent request arrives.
- R7: An accept with no request pending clears `gnt_valid` at that edge. An accept while requests are pending loads the next winner at the same edge, so one grant is issued per cycle.
- R8: Within the decode class, an over-length instruction (vector 13) wins over an illegal opcode (vector 6).
- R9: After reset, `gnt_valid`, `gnt_class`, `gnt_vec` and `intr_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mchk_req | input | 1 | Machine-check request |
| tsw_req | input | 1 | Task-switch trap request |
| intv_req | input | 1 | External intervention request |
| intv_vec | input | 8 | Vector for the intervention |
| brk_req | input | 1 | Breakpoint trap request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| intr_req | input | 1 | Maskable interrupt request |
| intr_vec | input | 8 | Vector supplied with the maskable interrupt |
| int_en | input | 1 | Interrupt-enable flag |
| fetch_req | input | 1 | Fetch fault request |
| fetch_vec | input | 8 | Vector for the fetch fault |
| dlen_req | input | 1 | Over-length instruction decode fault |
| dud_req | input | 1 | Illegal opcode decode fault |
| exe_req | input | 1 | Execute fault request |
| exe_vec | input | 8 | Vector for the execute fault |
| gnt_take | input | 1 | Consumer accepts the held grant |
| gnt_valid | output | 1 | A grant is held |
| gnt_class | output | 3 | Class of the held grant |
| gnt_vec | output | 8 | Vector of the held grant |
| intr_err | output | 1 | Maskable interrupt with an illegal vector was seen |

## Verification
Every result is one register away from its inputs. A grant, a cleared grant and `intr_err` all appear right after the first rising edge that samples the stimulus, and the holding register only reloads at an edge where it is free. The bench therefore drives inputs just after a falling edge, waits through one rising edge, and compares the outputs at the next falling edge. To check the hold behaviour it changes the requests while the accept is low and samples again one edge later. Expected class and vector come from a priority model written independently in the bench.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int VW = 8;
  localparam int CW = 3;

  localparam logic [VW-1:0] V_MCHK = 8'd18;
  localparam logic [VW-1:0] V_TSW  = 8'd1;
  localparam logic [VW-1:0] V_BRK  = 8'd3;
  localparam logic [VW-1:0] V_NMI  = 8'd2;
  localparam logic [VW-1:0] V_DLEN = 8'd13;
  localparam logic [VW-1:0] V_DUD  = 8'd6;

  typedef struct packed {
    logic          hit;
    logic [CW-1:0] cls;
    logic [VW-1:0] vec;
  } pick_t;

  // Fixed processor ordering; the first true test wins.
  function automatic pick_t pick_evt(
    input logic mchk, input logic tsw,
    input logic intv, input logic [VW-1:0] intv_v,
    input logic brk, input logic nmi,
    input logic intr_ok, input logic [VW-1:0] intr_v,
    input logic fetch, input logic [VW-1:0] fetch_v,
    input logic dlen, input logic dud,
    input logic exe, input logic [VW-1:0] exe_v);
    pick_t p;
    p = '0;
    if (mchk)         p = '{1'b1, 3'd0, V_MCHK};
    else if (tsw)     p = '{1'b1, 3'd1, V_TSW};
    else if (intv)    p = '{1'b1, 3'd2, intv_v};
    else if (brk)     p = '{1'b1, 3'd3, V_BRK};
    else if (nmi)     p = '{1'b1, 3'd4, V_NMI};
    else if (intr_ok) p = '{1'b1, 3'd4, intr_v};
    else if (fetch)   p = '{1'b1, 3'd5, fetch_v};
    else if (dlen)    p = '{1'b1, 3'd6, V_DLEN};
    else if (dud)     p = '{1'b1, 3'd6, V_DUD};
    else if (exe)     p = '{1'b1, 3'd7, exe_v};
    return p;
  endfunction
endpackage

// File: rtl/evt_gate.sv
module evt_gate #(
  parameter int VW        = 8,
  parameter int USER_BASE = 32
) (
  input  logic          intr_req,
  input  logic          int_en,
  input  logic [VW-1:0] intr_vec,
  output logic          intr_ok,
  output logic          intr_bad
);
  localparam logic [VW-1:0] BASE = VW'(USER_BASE);

  logic seen;
  logic in_user;

  assign seen     = intr_req && int_en;
  assign in_user  = (intr_vec >= BASE);
  assign intr_ok  = seen && in_user;
  assign intr_bad = seen && !in_user;
endmodule

// File: rtl/evt_select.sv
module evt_select
  import evt_pkg::*;
(
  input  logic          mchk_req,
  input  logic          tsw_req,
  input  logic          intv_req,
  input  logic [VW-1:0] intv_vec,
  input  logic          brk_req,
  input  logic          nmi_req,
  input  logic          intr_ok,
  input  logic [VW-1:0] intr_vec,
  input  logic          fetch_req,
  input  logic [VW-1:0] fetch_vec,
  input  logic          dlen_req,
  input  logic          dud_req,
  input  logic          exe_req,
  input  logic [VW-1:0] exe_vec,
  output pick_t         win
);
  always_comb begin
    win = pick_evt(mchk_req, tsw_req, intv_req, intv_vec, brk_req, nmi_req,
                   intr_ok, intr_vec, fetch_req, fetch_vec, dlen_req,
                   dud_req, exe_req, exe_vec);
  end
endmodule

// File: rtl/evt_hold.sv
module evt_hold
  import evt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  pick_t         nxt,
  input  logic          bad_in,
  output logic          load_en,
  output logic          gnt_valid,
  output logic [CW-1:0] gnt_class,
  output logic [VW-1:0] gnt_vec,
  output logic          intr_err
);
  assign load_en = !gnt_valid || take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_valid <= 1'b0;
      gnt_class <= '0;
      gnt_vec   <= '0;
      intr_err  <= 1'b0;
    end else begin
      intr_err <= bad_in;
      if (load_en) begin
        gnt_valid <= nxt.hit;
        if (nxt.hit) begin
          gnt_class <= nxt.cls;
          gnt_vec   <= nxt.vec;
        end
      end
    end
  end

  // R6: an unaccepted grant keeps its content
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && !take |=> gnt_valid && $stable(gnt_class) && $stable(gnt_vec));

  // R7: accept with nothing waiting empties the register
  p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && take && !nxt.hit |=> !gnt_valid);
endmodule

// File: rtl/evt_arbiter.sv
module evt_arbiter
  import evt_pkg::*;
#(
  parameter int USER_BASE = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mchk_req,
  input  logic          tsw_req,
  input  logic          intv_req,
  input  logic [7:0]    intv_vec,
  input  logic          brk_req,
  input  logic          nmi_req,
  input  logic          intr_req,
  input  logic [7:0]    intr_vec,
  input  logic          int_en,
  input  logic          fetch_req,
  input  logic [7:0]    fetch_vec,
  input  logic          dlen_req,
  input  logic          dud_req,
  input  logic          exe_req,
  input  logic [7:0]    exe_vec,
  input  logic          gnt_take,
  output logic          gnt_valid,
  output logic [2:0]    gnt_class,
  output logic [7:0]    gnt_vec,
  output logic          intr_err
);
  logic  intr_ok;
  logic  intr_bad;
  logic  slot_free;
  pick_t win;

  evt_gate #(.VW(VW), .USER_BASE(USER_BASE)) u_gate (
    .intr_req (intr_req),
    .int_en   (int_en),
    .intr_vec (intr_vec),
    .intr_ok  (intr_ok),
    .intr_bad (intr_bad)
  );

  evt_select u_sel (
    .mchk_req  (mchk_req),
    .tsw_req   (tsw_req),
    .intv_req  (intv_req),
    .intv_vec  (intv_vec),
    .brk_req   (brk_req),
    .nmi_req   (nmi_req),
    .intr_ok   (intr_ok),
    .intr_vec  (intr_vec),
    .fetch_req (fetch_req),
    .fetch_vec (fetch_vec),
    .dlen_req  (dlen_req),
    .dud_req   (dud_req),
    .exe_req   (exe_req),
    .exe_vec   (exe_vec),
    .win       (win)
  );

  evt_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (gnt_take),
    .nxt       (win),
    .bad_in    (intr_bad),
    .load_en   (slot_free),
    .gnt_valid (gnt_valid),
    .gnt_class (gnt_class),
    .gnt_vec   (gnt_vec),
    .intr_err  (intr_err)
  );

  // R1: a machine check taken into a free slot always wins
  p_mchk_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_free && mchk_req |=> gnt_valid && gnt_class == 3'd0 && gnt_vec == 8'd18);

  // R3: NMI beats everything below class 3, independent of the flag
  p_nmi_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_free && nmi_req && !mchk_req && !tsw_req && !intv_req && !brk_req
    |=> gnt_valid && gnt_class == 3'd4 && gnt_vec == 8'd2);

  // R4: a masked interrupt never reaches the grant register
  p_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    slot_free && !int_en && intr_req && !mchk_req && !tsw_req && !intv_req &&
    !brk_req && !nmi_req && !fetch_req && !dlen_req && !dud_req && !exe_req
    |=> !gnt_valid);

  // R5: the error flag only follows a low vector
  p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    intr_err |-> $past(intr_vec) < 8'(USER_BASE) && $past(int_en));
endmodule

// File: tb/sim_evt_arbiter.sv
module sim_evt_arbiter;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mchk_req, tsw_req, intv_req, brk_req, nmi_req, intr_req, int_en;
  logic fetch_req, dlen_req, dud_req, exe_req, gnt_take;
  logic [7:0] intv_vec, intr_vec, fetch_vec, exe_vec;
  logic gnt_valid, intr_err;
  logic [2:0] gnt_class;
  logic [7:0] gnt_vec;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  evt_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .mchk_req(mchk_req), .tsw_req(tsw_req),
    .intv_req(intv_req), .intv_vec(intv_vec), .brk_req(brk_req),
    .nmi_req(nmi_req), .intr_req(intr_req), .intr_vec(intr_vec),
    .int_en(int_en), .fetch_req(fetch_req), .fetch_vec(fetch_vec),
    .dlen_req(dlen_req), .dud_req(dud_req), .exe_req(exe_req),
    .exe_vec(exe_vec), .gnt_take(gnt_take), .gnt_valid(gnt_valid),
    .gnt_class(gnt_class), .gnt_vec(gnt_vec), .intr_err(intr_err)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic expect_gnt(input string rq, input bit v, input int cls, input int vec);
    chk(gnt_valid == v, {rq, " valid"}, gnt_valid, v);
    if (v) begin
      chk(gnt_class == cls, {rq, " class"}, gnt_class, cls);
      chk(gnt_vec == vec, {rq, " vector"}, gnt_vec, vec);
    end
  endtask

  task automatic quiet();
    mchk_req = 0; tsw_req = 0; intv_req = 0; brk_req = 0; nmi_req = 0;
    intr_req = 0; fetch_req = 0; dlen_req = 0; dud_req = 0; exe_req = 0;
    intv_vec = 8'h50; intr_vec = 8'h40; fetch_vec = 8'd14; exe_vec = 8'd0;
    int_en = 1; gnt_take = 1;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    quiet();
    rst_n = 0;
    step();
    chk(gnt_valid == 0, "R9 valid", gnt_valid, 0);
    chk(gnt_class == 0, "R9 class", gnt_class, 0);
    chk(gnt_vec == 0, "R9 vector", gnt_vec, 0);
    chk(intr_err == 0, "R9 err", intr_err, 0);
    rst_n = 1;
    step();
  endtask

  task automatic t_order();
    quiet();
    mchk_req = 1; tsw_req = 1; intv_req = 1; brk_req = 1; nmi_req = 1;
    intr_req = 1; fetch_req = 1; dlen_req = 1; dud_req = 1; exe_req = 1;
    exe_vec = 8'd0;
    step(); expect_gnt("R1 R2 mchk", 1, 0, 18);
    mchk_req = 0; step(); expect_gnt("R1 R2 tsw", 1, 1, 1);
    tsw_req = 0; step(); expect_gnt("R1 R2 intv", 1, 2, 8'h50);
    intv_req = 0; step(); expect_gnt("R1 R2 brk", 1, 3, 3);
    brk_req = 0; step(); expect_gnt("R1 R3 nmi", 1, 4, 2);
    nmi_req = 0; step(); expect_gnt("R1 R4 intr", 1, 4, 8'h40);
    intr_req = 0; step(); expect_gnt("R1 R2 fetch", 1, 5, 14);
    fetch_req = 0; step(); expect_gnt("R1 R8 dlen", 1, 6, 13);
    dlen_req = 0; step(); expect_gnt("R1 R8 dud", 1, 6, 6);
    dud_req = 0; step(); expect_gnt("R1 R2 exe", 1, 7, 0);
    exe_req = 0; step(); expect_gnt("R7 drop", 0, 0, 0);
  endtask

  task automatic t_mask();
    quiet();
    int_en = 0; intr_req = 1; intr_vec = 8'h80;
    step(); expect_gnt("R4 masked", 0, 0, 0);
    chk(intr_err == 0, "R4 masked err", intr_err, 0);
    nmi_req = 1;
    step(); expect_gnt("R3 nmi masked flag", 1, 4, 2);
    nmi_req = 0; int_en = 1;
    step(); expect_gnt("R4 enabled", 1, 4, 8'h80);
    intr_req = 0; step();
  endtask

  task automatic t_err();
    quiet();
    intr_req = 1; intr_vec = 8'd5;
    step(); expect_gnt("R5 low vec", 0, 0, 0);
    chk(intr_err == 1, "R5 err set", intr_err, 1);
    intr_vec = 8'd31;
    step(); chk(intr_err == 1, "R5 err 31", intr_err, 1);
    expect_gnt("R5 vec 31", 0, 0, 0);
    intr_vec = 8'd32;
    step(); chk(intr_err == 0, "R5 err 32", intr_err, 0);
    expect_gnt("R5 vec 32", 1, 4, 32);
    intr_req = 0; step();
    chk(intr_err == 0, "R5 err clear", intr_err, 0);
  endtask

  task automatic t_hold();
    quiet();
    exe_req = 1; exe_vec = 8'd0; gnt_take = 0;
    step(); expect_gnt("R6 load", 1, 7, 0);
    exe_req = 0; mchk_req = 1;
    step(); expect_gnt("R6 held", 1, 7, 0);
    step(); expect_gnt("R6 held again", 1, 7, 0);
    gnt_take = 1;
    step(); expect_gnt("R7 next on take", 1, 0, 18);
    mchk_req = 0;
    step(); expect_gnt("R7 empty", 0, 0, 0);
  endtask

  task automatic t_vectors();
    quiet();
    intv_req = 1; intv_vec = 8'hC3; fetch_req = 1;
    step(); expect_gnt("R2 intv vec", 1, 2, 8'hC3);
    intv_req = 0; fetch_vec = 8'd14;
    step(); expect_gnt("R2 fetch vec", 1, 5, 14);
    fetch_req = 0; dud_req = 1;
    step(); expect_gnt("R8 dud alone", 1, 6, 6);
    dud_req = 0; step();
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    quiet();
    @(negedge clk);
    t_reset();
    t_order();
    t_mask();
    t_err();
    t_hold();
    t_vectors();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule